// File: doc/BRIEF.md
# Charge Safety Timer with Host Watchdogs

This block decides whether the linear charger may pass current. It combines the charge-enable pin, the host's charge-disable bit and input-supply validity into one enable. A charge safety timer, driven by a once-per-second tick, limits how long a charge cycle may run. When that limit is reached, charging is locked off, a sticky flag is raised and the host gets a one-cycle interrupt. The lock can be released only by driving the charge-enable pin high or by removing the input supply. Reading the flag clears the flag, but the lock stays in place.

The timer limit depends on the charge phase: in pre-charge it is a quarter of the fast-charge limit. A double-time option slows the timer to half rate while a regulation loop other than constant current or constant voltage holds the charge current down. The timer freezes while the battery thermistor reports a too-cold or too-hot zone. Any change of the charge-current setting blanks the enable for a fixed number of clock cycles before the new value takes hold.

Two host watchdogs run beside the timer:
- **Bus-activity watchdog.** It restarts on every bus transaction. On expiry it pulses a request that returns the charger parameter registers to their defaults.
- **Adapter watchdog.** It arms when a valid adapter appears. If no transaction arrives within its window, it pulses a hardware-reset request once.

Top module: `chg_safety_wdt`

## Requirements
- R1: `chg_en_o` is 1 only when `ce_pin_i` is 0, `chg_dis_i` is 0 and `vin_ok_i` is 1, and there is neither a timer fault nor current-change blanking. Any other combination gives 0.
- R2: `dur_sel_i` selects the fast-charge limit as follows: code 0 gives LIM_A_MIN minutes, code 1 gives LIM_B_MIN and code 2 gives LIM_C_MIN. Each minute is SEC_PER_MIN ticks of `sec_tick_i`. Code 3 disables the timer, so no fault ever occurs. In fast phase (`phase_fast_i`=1), the fault occurs on the tick that completes the limit.
- R3: In pre-charge (`phase_fast_i`=0), the limit is one quarter of the selected fast-charge limit.
- R4: On expiry, `chg_en_o` drops to 0, `fault_flag_o` becomes 1 and `irq_o` pulses high for exactly one clock. No further pulse occurs while the fault persists.
- R5: The fault, and `chg_en_o`=0, survive a toggle of `chg_dis_i`. Driving `ce_pin_i` high, or `vin_ok_i` low, clears the fault and zeroes the timer.
- R6: A one-cycle `flag_rd_i` clears `fault_flag_o` even while the fault keeps `chg_en_o` at 0.
- R7: A change of `dur_sel_i`, or of `phase_fast_i`, restarts the timer from zero.
- R8: With `dbl_time_i`=1 and `loop_slow_i`=1, the timer needs twice as many ticks to expire. With `dbl_time_i`=0, `loop_slow_i` has no effect.
- R9: While `ts_susp_i`=1, ticks do not advance the timer.
- R10: With `wd_bus_en_i`=1, `regs_rst_o` pulses for one clock on the WD_BUS_SEC-th tick without a transaction (`bus_txn_i`). A transaction restarts the window. With the enable at 0, no pulse occurs.
- R11: With `wd_adp_en_i`=1, a rising `vin_ok_i` arms the adapter watchdog. `hw_rst_o` pulses once on the WD_ADP_SEC-th tick after arming, unless a transaction arrives first. It does not repeat until the watchdog is re-armed.
- R12: A one-cycle `ichg_chg_i` forces `chg_en_o` to 0 for BLANK_CYC clock cycles, starting the cycle after the pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick_i | input | 1 | One-cycle pulse once per second |
| ce_pin_i | input | 1 | Charge-enable pin, high disables |
| chg_dis_i | input | 1 | Host charge-disable bit |
| vin_ok_i | input | 1 | Input supply valid |
| phase_fast_i | input | 1 | 1 = fast charge, 0 = pre-charge |
| loop_slow_i | input | 1 | A non-CC/CV regulation loop is active |
| ts_susp_i | input | 1 | Thermistor cold or hot zone |
| dur_sel_i | input | 2 | Timer duration code |
| dbl_time_i | input | 1 | Double-time enable |
| wd_bus_en_i | input | 1 | Bus-activity watchdog enable |
| wd_adp_en_i | input | 1 | Adapter watchdog enable |
| bus_txn_i | input | 1 | One-cycle pulse per host bus transaction |
| flag_rd_i | input | 1 | Fault-flag read strobe |
| ichg_chg_i | input | 1 | Charge-current setting changed |
| chg_en_o | output | 1 | Charging permitted |
| fault_flag_o | output | 1 | Sticky safety-timer fault flag |
| irq_o | output | 1 | One-cycle interrupt on expiry |
| regs_rst_o | output | 1 | Parameter-register reset pulse |
| hw_rst_o | output | 1 | Hardware-reset request pulse |

## Verification
The bench builds the block with one-tick minutes and limits of 8, 16 and 4 minutes. This makes every fast-charge limit, its quarter-length pre-charge limit and its doubled length a few ticks long, so each expiry tick can be hit exactly. The watchdog windows are shortened to 5 and 3 ticks, and blanking to 5 cycles. With these values, both sides of every boundary, including restarts, suspension and one-shot behaviour, fit into short directed scenarios.

// File: rtl/chg_tmr_pkg.sv
package chg_tmr_pkg;

    typedef enum logic [1:0] {
        DUR_A   = 2'd0,
        DUR_B   = 2'd1,
        DUR_C   = 2'd2,
        DUR_OFF = 2'd3
    } dur_e;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/chg_safety_core.sv
module chg_safety_core
    import chg_tmr_pkg::*;
#(
    parameter int SEC_PER_MIN = 60,
    parameter int LIM_A_MIN   = 180,
    parameter int LIM_B_MIN   = 360,
    parameter int LIM_C_MIN   = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick_i,
    input  logic ce_pin_i,
    input  logic chg_dis_i,
    input  logic vin_ok_i,
    input  logic phase_fast_i,
    input  logic loop_slow_i,
    input  logic ts_susp_i,
    input  dur_e dur_sel_i,
    input  logic dbl_time_i,
    input  logic flag_rd_i,
    output logic fault_o,
    output logic flag_o,
    output logic irq_o
);

    localparam int MAX_HALF = max3(LIM_A_MIN, LIM_B_MIN, LIM_C_MIN) * SEC_PER_MIN * 2;
    localparam int CNT_W    = $clog2(MAX_HALF + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             fault;
        logic             flag;
        logic             irq;
        dur_e             dur_prev;
        logic             fast_prev;
    } core_st_t;

    core_st_t s_d, s_q;

    logic [CNT_W-1:0] full_sec;
    logic [CNT_W-1:0] lim_half;
    logic [1:0]       inc;
    logic [CNT_W:0]   nxt;
    logic             run;

    always_comb begin
        unique case (dur_sel_i)
            DUR_A:   full_sec = CNT_W'(LIM_A_MIN * SEC_PER_MIN);
            DUR_B:   full_sec = CNT_W'(LIM_B_MIN * SEC_PER_MIN);
            DUR_C:   full_sec = CNT_W'(LIM_C_MIN * SEC_PER_MIN);
            default: full_sec = '0;
        endcase
        // counts are in half-seconds; pre-charge gets a quarter of the time
        lim_half = phase_fast_i ? (full_sec << 1) : (full_sec >> 1);
        if (ts_susp_i)                     inc = 2'd0;
        else if (dbl_time_i && loop_slow_i) inc = 2'd1;
        else                               inc = 2'd2;
        run = !ce_pin_i && !chg_dis_i && vin_ok_i && !s_q.fault && (dur_sel_i != DUR_OFF);
        nxt = {1'b0, s_q.cnt} + {{(CNT_W-1){1'b0}}, inc};

        s_d           = s_q;
        s_d.irq       = 1'b0;
        s_d.dur_prev  = dur_sel_i;
        s_d.fast_prev = phase_fast_i;
        if (flag_rd_i) s_d.flag = 1'b0;

        if (ce_pin_i || !vin_ok_i) begin
            s_d.cnt   = '0;
            s_d.fault = 1'b0;
        end else if (dur_sel_i != s_q.dur_prev || phase_fast_i != s_q.fast_prev) begin
            s_d.cnt = '0;
        end else if (run && sec_tick_i) begin
            if (nxt >= {1'b0, lim_half}) begin
                s_d.cnt   = '0;
                s_d.fault = 1'b1;
                s_d.flag  = 1'b1;
                s_d.irq   = 1'b1;
            end else begin
                s_d.cnt = nxt[CNT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{cnt: '0, fault: 1'b0, flag: 1'b0, irq: 1'b0,
                     dur_prev: DUR_A, fast_prev: 1'b1};
        end else begin
            s_q <= s_d;
        end
    end

    assign fault_o = s_q.fault;
    assign flag_o  = s_q.flag;
    assign irq_o   = s_q.irq;

    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.irq |=> !s_q.irq); // R4
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fault && !ce_pin_i && vin_ok_i |=> s_q.fault); // R5
    AST_FLAG_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        flag_rd_i && s_q.fault |=> !s_q.flag); // R6
    AST_CNT_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < CNT_W'(MAX_HALF)); // R2
    AST_OFF_NEVER_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
        dur_sel_i == DUR_OFF && s_q.dur_prev == DUR_OFF && !s_q.fault |=> !s_q.fault); // R2

endmodule

// File: rtl/chg_blank.sv
module chg_blank #(
    parameter int BLANK_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic chg_i,
    output logic active_o
);

    localparam int BW = $clog2(BLANK_CYC + 1);

    typedef struct packed {
        logic [BW-1:0] cnt;
    } blank_st_t;

    blank_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (chg_i)               s_d.cnt = BW'(BLANK_CYC);
        else if (s_q.cnt != '0)  s_d.cnt = s_q.cnt - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cnt: '0};
        else        s_q <= s_d;
    end

    assign active_o = (s_q.cnt != '0);

    AST_BLANK_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        chg_i |=> active_o); // R12
    AST_BLANK_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= BW'(BLANK_CYC)); // R12

endmodule

// File: rtl/host_wdog.sv
module host_wdog #(
    parameter int LIMIT_SEC = 50,
    parameter bit ONE_SHOT  = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic kick_i,
    input  logic start_i,
    output logic expire_o
);

    localparam int CW = $clog2(LIMIT_SEC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          armed;
        logic          expire;
    } wd_st_t;

    wd_st_t s_d, s_q;
    logic   armed_eff;

    generate
        if (ONE_SHOT) begin : g_one_shot
            assign armed_eff = s_q.armed;
        end else begin : g_continuous
            assign armed_eff = 1'b1;
        end
    endgenerate

    always_comb begin
        s_d        = s_q;
        s_d.expire = 1'b0;
        if (!en_i) begin
            s_d.cnt   = '0;
            s_d.armed = 1'b0;
        end else if (kick_i) begin
            s_d.cnt   = '0;
            s_d.armed = 1'b0;
        end else if (start_i) begin
            s_d.cnt   = '0;
            s_d.armed = 1'b1;
        end else if (armed_eff && tick_i) begin
            if (s_q.cnt == CW'(LIMIT_SEC - 1)) begin
                s_d.cnt    = '0;
                s_d.expire = 1'b1;
                s_d.armed  = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{cnt: '0, armed: 1'b0, expire: 1'b0};
        else        s_q <= s_d;
    end

    assign expire_o = s_q.expire;

    AST_WD_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt < CW'(LIMIT_SEC)); // R10
    AST_KICK_NO_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        kick_i |=> !s_q.expire); // R11
    AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.expire |=> !s_q.expire); // R10

endmodule

// File: rtl/chg_safety_wdt.sv
module chg_safety_wdt
    import chg_tmr_pkg::*;
#(
    parameter int SEC_PER_MIN = 60,
    parameter int LIM_A_MIN   = 180,
    parameter int LIM_B_MIN   = 360,
    parameter int LIM_C_MIN   = 600,
    parameter int WD_BUS_SEC  = 50,
    parameter int WD_ADP_SEC  = 14,
    parameter int BLANK_CYC   = 250000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sec_tick_i,
    input  logic       ce_pin_i,
    input  logic       chg_dis_i,
    input  logic       vin_ok_i,
    input  logic       phase_fast_i,
    input  logic       loop_slow_i,
    input  logic       ts_susp_i,
    input  logic [1:0] dur_sel_i,
    input  logic       dbl_time_i,
    input  logic       wd_bus_en_i,
    input  logic       wd_adp_en_i,
    input  logic       bus_txn_i,
    input  logic       flag_rd_i,
    input  logic       ichg_chg_i,
    output logic       chg_en_o,
    output logic       fault_flag_o,
    output logic       irq_o,
    output logic       regs_rst_o,
    output logic       hw_rst_o
);

    logic fault, blank;
    logic vin_prev_d, vin_prev_q;
    logic adp_start;

    chg_safety_core #(
        .SEC_PER_MIN (SEC_PER_MIN),
        .LIM_A_MIN   (LIM_A_MIN),
        .LIM_B_MIN   (LIM_B_MIN),
        .LIM_C_MIN   (LIM_C_MIN)
    ) core_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sec_tick_i   (sec_tick_i),
        .ce_pin_i     (ce_pin_i),
        .chg_dis_i    (chg_dis_i),
        .vin_ok_i     (vin_ok_i),
        .phase_fast_i (phase_fast_i),
        .loop_slow_i  (loop_slow_i),
        .ts_susp_i    (ts_susp_i),
        .dur_sel_i    (dur_e'(dur_sel_i)),
        .dbl_time_i   (dbl_time_i),
        .flag_rd_i    (flag_rd_i),
        .fault_o      (fault),
        .flag_o       (fault_flag_o),
        .irq_o        (irq_o)
    );

    chg_blank #(.BLANK_CYC(BLANK_CYC)) blank_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .chg_i    (ichg_chg_i),
        .active_o (blank)
    );

    host_wdog #(.LIMIT_SEC(WD_BUS_SEC), .ONE_SHOT(1'b0)) wd_bus_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (wd_bus_en_i),
        .tick_i   (sec_tick_i),
        .kick_i   (bus_txn_i),
        .start_i  (1'b0),
        .expire_o (regs_rst_o)
    );

    always_comb begin
        vin_prev_d = vin_ok_i;
        adp_start  = vin_ok_i && !vin_prev_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vin_prev_q <= 1'b0;
        else        vin_prev_q <= vin_prev_d;
    end

    host_wdog #(.LIMIT_SEC(WD_ADP_SEC), .ONE_SHOT(1'b1)) wd_adp_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (wd_adp_en_i && vin_ok_i),
        .tick_i   (sec_tick_i),
        .kick_i   (bus_txn_i),
        .start_i  (adp_start),
        .expire_o (hw_rst_o)
    );

    assign chg_en_o = !ce_pin_i && !chg_dis_i && vin_ok_i && !fault && !blank;

    AST_IRQ_MEANS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> !chg_en_o); // R4
    AST_BLANK_HOLDS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        ichg_chg_i |=> !chg_en_o); // R12

endmodule

// File: tb/chg_safety_wdt_tb_top.sv
module chg_safety_wdt_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_tick = 0, ce_pin = 0, chg_dis = 0, vin_ok = 1, phase_fast = 1;
    logic loop_slow = 0, ts_susp = 0, dbl_time = 0;
    logic wd_bus_en = 0, wd_adp_en = 0, bus_txn = 0, flag_rd = 0, ichg_chg = 0;
    logic [1:0] dur_sel = 2'd0;
    logic chg_en, fault_flag, irq, regs_rst, hw_rst;

    int errors = 0;
    int checks = 0;
    int n_irq = 0, n_regs = 0, n_hw = 0;
    bit done = 0;

    always #2 clk = ~clk;

    chg_safety_wdt #(
        .SEC_PER_MIN(1), .LIM_A_MIN(8), .LIM_B_MIN(16), .LIM_C_MIN(4),
        .WD_BUS_SEC(5), .WD_ADP_SEC(3), .BLANK_CYC(5)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .sec_tick_i(sec_tick), .ce_pin_i(ce_pin),
        .chg_dis_i(chg_dis), .vin_ok_i(vin_ok), .phase_fast_i(phase_fast),
        .loop_slow_i(loop_slow), .ts_susp_i(ts_susp), .dur_sel_i(dur_sel),
        .dbl_time_i(dbl_time), .wd_bus_en_i(wd_bus_en), .wd_adp_en_i(wd_adp_en),
        .bus_txn_i(bus_txn), .flag_rd_i(flag_rd), .ichg_chg_i(ichg_chg),
        .chg_en_o(chg_en), .fault_flag_o(fault_flag), .irq_o(irq),
        .regs_rst_o(regs_rst), .hw_rst_o(hw_rst)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (irq)      n_irq++;
            if (regs_rst) n_regs++;
            if (hw_rst)   n_hw++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            sec_tick = 1'b1;
            @(negedge clk);
            sec_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic restart_cycle();
        ce_pin = 1'b1; step(1);
        ce_pin = 1'b0; step(1);
        flag_rd = 1'b1; step(1);
        flag_rd = 1'b0; step(1);
    endtask

    task automatic t_reset();
        check("R1 reset chg_en", chg_en, 1);
        check("R4 reset flag", fault_flag, 0);
        check("R10 reset regs_rst", n_regs, 0);
    endtask

    task automatic t_enable_truth();
        chg_dis = 1; step(1); check("R1 dis bit", chg_en, 0);
        chg_dis = 0; ce_pin = 1; step(1); check("R1 ce pin", chg_en, 0);
        ce_pin = 0; vin_ok = 0; step(1); check("R1 vin", chg_en, 0);
        vin_ok = 1; step(1); check("R1 all ok", chg_en, 1);
    endtask

    task automatic t_fast_expiry();
        int irq0;
        dur_sel = 2'd0; phase_fast = 1; step(1); restart_cycle();
        irq0 = n_irq;
        tick(7);
        check("R2 before limit", fault_flag, 0);
        check("R2 still enabled", chg_en, 1);
        tick(1);
        check("R4 flag set", fault_flag, 1);
        check("R4 chg off", chg_en, 0);
        check("R4 one irq", n_irq - irq0, 1);
        tick(5);
        check("R4 no repeat irq", n_irq - irq0, 1);
        chg_dis = 1; step(1); chg_dis = 0; step(1);
        check("R5 dis toggle keeps fault", chg_en, 0);
        flag_rd = 1; step(1); flag_rd = 0; step(1);
        check("R6 flag cleared", fault_flag, 0);
        check("R6 fault persists", chg_en, 0);
        ce_pin = 1; step(1); ce_pin = 0; step(1);
        check("R5 ce toggle clears", chg_en, 1);
        tick(7);
        check("R5 timer zeroed", chg_en, 1);
        tick(1);
        check("R5 expires again", chg_en, 0);
        vin_ok = 0; step(1); vin_ok = 1; step(1);
        check("R5 vin toggle clears", chg_en, 1);
    endtask

    task automatic t_pre_and_phase();
        dur_sel = 2'd0; phase_fast = 1; step(1); restart_cycle();
        tick(6);
        phase_fast = 0; step(1);
        tick(1);
        check("R7 phase change restarts", chg_en, 1);
        tick(1);
        check("R3 pre limit quarter", chg_en, 0);
    endtask

    task automatic t_dur_change();
        dur_sel = 2'd0; phase_fast = 1; step(1); restart_cycle();
        tick(5);
        dur_sel = 2'd1; step(1);
        tick(15);
        check("R7 dur change restarts", chg_en, 1);
        tick(1);
        check("R2 code1 limit", chg_en, 0);
    endtask

    task automatic t_double();
        dur_sel = 2'd2; phase_fast = 1; step(1); restart_cycle();
        dbl_time = 1; loop_slow = 1;
        tick(7);
        check("R8 half rate not yet", chg_en, 1);
        tick(1);
        check("R8 half rate expiry", chg_en, 0);
        restart_cycle();
        dbl_time = 0;
        tick(3);
        check("R8 no dbl before", chg_en, 1);
        tick(1);
        check("R8 no dbl expiry", chg_en, 0);
        loop_slow = 0;
    endtask

    task automatic t_suspend();
        dur_sel = 2'd2; step(1); restart_cycle();
        tick(2);
        ts_susp = 1; tick(10); ts_susp = 0;
        check("R9 frozen", chg_en, 1);
        tick(1);
        check("R9 resumes", chg_en, 1);
        tick(1);
        check("R9 expiry after resume", chg_en, 0);
    endtask

    task automatic t_off();
        dur_sel = 2'd3; step(1); restart_cycle();
        tick(40);
        check("R2 code3 disabled", chg_en, 1);
    endtask

    task automatic t_blank();
        ichg_chg = 1; step(1); ichg_chg = 0;
        check("R12 blank start", chg_en, 0);
        step(4);
        check("R12 blank held", chg_en, 0);
        step(1);
        check("R12 blank ends", chg_en, 1);
    endtask

    task automatic t_bus_wd();
        int r0;
        r0 = n_regs;
        wd_bus_en = 1; step(1);
        tick(4);
        check("R10 before window", n_regs - r0, 0);
        tick(1);
        check("R10 expiry pulse", n_regs - r0, 1);
        tick(3);
        bus_txn = 1; step(1); bus_txn = 0;
        tick(4);
        check("R10 txn restarts", n_regs - r0, 1);
        tick(1);
        check("R10 second expiry", n_regs - r0, 2);
        wd_bus_en = 0; step(1);
        tick(10);
        check("R10 disabled", n_regs - r0, 2);
    endtask

    task automatic t_adp_wd();
        int h0;
        h0 = n_hw;
        wd_adp_en = 1;
        vin_ok = 0; step(1); vin_ok = 1; step(1);
        tick(2);
        check("R11 before window", n_hw - h0, 0);
        tick(1);
        check("R11 reset request", n_hw - h0, 1);
        tick(6);
        check("R11 one shot", n_hw - h0, 1);
        vin_ok = 0; step(1); vin_ok = 1; step(1);
        tick(2);
        bus_txn = 1; step(1); bus_txn = 0;
        tick(5);
        check("R11 txn disarms", n_hw - h0, 1);
        wd_adp_en = 0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_enable_truth();
        t_fast_expiry();
        t_pre_and_phase();
        t_dur_change();
        t_double();
        t_suspend();
        t_off();
        t_blank();
        t_bus_wd();
        t_adp_wd();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule